// File: doc/BRIEF.md
# LIN Slave Header Auto-Baud Detector

This block sits in front of a LIN slave's UART and finds the start of each frame header. Software arms it with a single strobe. The block then watches the synchronised receive line for a low stretch that lasts at least a programmable number of clock cycles. That stretch is the Synch Break. After the break it waits for the Synch Field, which is the byte 55h sent LSB first. It times the span from the falling edge that opens the start bit to the falling edge that opens data bit 7. That span is eight bit times, so the measured count shifted right by three is the bit period in clock cycles. The bit period is presented with a one-cycle valid strobe, and the companion UART uses it to receive the identifier byte.

Sticky flags report three events: break found, sync measured and sync counter overflow. Each flag has its own write-one-to-clear input. Break and sync interrupt requests are the matching flag gated by an enable bit. While the block is hunting for the header, the UART's receive input is held at the idle level. During measurement a configuration bit chooses whether the Synch Field is also passed to the UART.

Top module: `lin_hdr_autobaud`

## Requirements
- R1: `rx_i` passes through a two-flop synchroniser. While idle, `uart_rx_o` equals `rx_i` delayed by exactly two clock cycles, and the synchroniser flops reset to 1.
- R2: Break detection runs only after a pulse on `arm_i`. Line activity before arming sets no flag. A new `arm_i` pulse restarts break detection from any state.
- R3: From arming until the first falling edge after a detected break, `uart_rx_o` is held at 1 whatever the line does.
- R4: A break is detected when the synchronised line has been low for `brk_thresh_i` consecutive cycles. A run one cycle shorter is not a break. Detection sets `brk_flag_o`, and `brk_irq_o` is `brk_flag_o` AND `brk_irq_en_i`.
- R5: A high sample before the threshold is reached restarts the low-time count from zero. Two short low runs separated by one high cycle never add up to a break.
- R6: After a break, measurement starts at the first falling edge and ends at the fifth falling edge. At the end, `sync_flag_o` is set, `period_valid_o` pulses high for exactly one cycle, and `sync_irq_o` is `sync_flag_o` AND `sync_irq_en_i`.
- R7: `bit_period_o` is the count of cycles between the first and fifth falling edges, shifted right by 3. For a 55h sync byte with a bit period of P cycles, this equals P. The value changes only together with `period_valid_o`.
- R8: A 1 on `brk_flag_clr_i`, `sync_flag_clr_i` or `err_flag_clr_i` clears only its own flag in the next cycle. If a flag is set and cleared in the same cycle, it stays set.
- R9: If the measurement count reaches all-ones (CNT_W bits) before the fifth falling edge, `err_flag_o` is set. `bit_period_o` is left unchanged, and the block returns to break detection without needing a new `arm_i`.
- R10: During measurement, `uart_rx_o` follows the synchronised line when `sync_pass_i` is 1 and is held at 1 when it is 0.
- R11: After a completed measurement, `uart_rx_o` again follows the synchronised line, so the UART can receive the identifier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | LIN receive line, asynchronous |
| arm_i | input | 1 | Start strobe: begin hunting for a break |
| brk_thresh_i | input | BRK_W | Minimum low time of a break, in cycles |
| brk_irq_en_i | input | 1 | Break interrupt enable |
| sync_irq_en_i | input | 1 | Sync-done interrupt enable |
| sync_pass_i | input | 1 | Pass the Synch Field to the UART during measurement |
| brk_flag_clr_i | input | 1 | Write-one-to-clear for the break flag |
| sync_flag_clr_i | input | 1 | Write-one-to-clear for the sync flag |
| err_flag_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| uart_rx_o | output | 1 | Gated receive line to the UART |
| brk_flag_o | output | 1 | Break detected |
| sync_flag_o | output | 1 | Sync measurement done |
| err_flag_o | output | 1 | Sync count overflowed |
| brk_irq_o | output | 1 | Break interrupt request |
| sync_irq_o | output | 1 | Sync interrupt request |
| bit_period_o | output | CNT_W-3 | Measured bit period in cycles |
| period_valid_o | output | 1 | One-cycle strobe when a new bit period is available |

## Verification
Some properties are checked on every cycle:
- the UART line stays idle while the block hunts for the header;
- the valid strobe lasts one cycle and always coincides with the sync flag;
- the bit period never moves without that strobe;
- interrupt requests never appear without both flag and enable;
- a clear with no competing set empties the break flag;
- an overflow always lands the block back in break detection.

Other behaviour can only be shown by the bench's scenarios:
- the exact break threshold boundary and the reset of the low count by a short high;
- the measured period value across several bit rates;
- the two-cycle synchroniser delay;
- the pass-through choice during the sync byte;
- recovery from an overflow into a fresh header.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BREAK = 2'd1,
        ST_WAIT  = 2'd2,
        ST_MEAS  = 2'd3
    } lin_state_e;

    localparam int unsigned SYNC_FALLS = 5;
    localparam int unsigned BIT_SHIFT  = 3;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.meta = rx_i;
        r_d.sync = r_q.meta;
        r_d.prev = r_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
        else        r_q <= r_d;
    end

    assign rx_s_o = r_q.sync;
    assign fall_o = r_q.prev & ~r_q.sync;

endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int unsigned BRK_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             low_i,
    input  logic [BRK_W-1:0] thresh_i,
    output logic             hit_o
);

    localparam int unsigned CW = BRK_W + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q == {CW{1'b1}}) ? cnt_q : cnt_q + 1'b1;
        hit_o   = run_i & low_i & (cnt_inc >= {1'b0, thresh_i});
        if (clear_i || !run_i || !low_i) cnt_d = '0;
        else                             cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic             fall_i,
    output logic             done_o,
    output logic             ovf_o,
    output logic [CNT_W-4:0] period_o
);

    import lin_hdr_pkg::*;

    localparam int unsigned EW = 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [EW-1:0]    falls;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        done_o   = run_i & fall_i & (r_q.falls == EW'(SYNC_FALLS - 1));
        ovf_o    = run_i & ~done_o & (r_q.cnt == {CNT_W{1'b1}});
        period_o = r_q.cnt[CNT_W-1:BIT_SHIFT];
        r_d      = r_q;
        if (start_i) begin
            r_d.cnt   = CNT_W'(1);
            r_d.falls = EW'(1);
        end else if (run_i) begin
            r_d.cnt   = r_q.cnt + 1'b1;
            r_d.falls = r_q.falls + EW'(fall_i);
        end else begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/lin_hdr_autobaud.sv
module lin_hdr_autobaud #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned BRK_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             arm_i,
    input  logic [BRK_W-1:0] brk_thresh_i,
    input  logic             brk_irq_en_i,
    input  logic             sync_irq_en_i,
    input  logic             sync_pass_i,
    input  logic             brk_flag_clr_i,
    input  logic             sync_flag_clr_i,
    input  logic             err_flag_clr_i,
    output logic             uart_rx_o,
    output logic             brk_flag_o,
    output logic             sync_flag_o,
    output logic             err_flag_o,
    output logic             brk_irq_o,
    output logic             sync_irq_o,
    output logic [CNT_W-4:0] bit_period_o,
    output logic             period_valid_o
);

    import lin_hdr_pkg::*;

    localparam int unsigned PER_W = CNT_W - 3;

    typedef struct packed {
        lin_state_e       st;
        logic             brk;
        logic             sync;
        logic             err;
        logic             vld;
        logic [PER_W-1:0] per;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             rx_s, fall;
    logic             brk_hit;
    logic             meas_start, meas_done, meas_ovf;
    logic [PER_W-1:0] meas_per;

    lin_rx_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_s_o (rx_s),
        .fall_o (fall)
    );

    lin_low_timer #(.BRK_W(BRK_W)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (arm_i),
        .run_i    (r_q.st == ST_BREAK),
        .low_i    (~rx_s),
        .thresh_i (brk_thresh_i),
        .hit_o    (brk_hit)
    );

    lin_sync_timer #(.CNT_W(CNT_W)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (meas_start),
        .run_i    (r_q.st == ST_MEAS),
        .fall_i   (fall),
        .done_o   (meas_done),
        .ovf_o    (meas_ovf),
        .period_o (meas_per)
    );

    always_comb begin
        r_d        = r_q;
        r_d.vld    = 1'b0;
        meas_start = 1'b0;

        // clears first, so an event in the same cycle wins
        if (brk_flag_clr_i)  r_d.brk  = 1'b0;
        if (sync_flag_clr_i) r_d.sync = 1'b0;
        if (err_flag_clr_i)  r_d.err  = 1'b0;

        unique case (r_q.st)
            ST_IDLE: ;
            ST_BREAK: begin
                if (brk_hit) begin
                    r_d.st  = ST_WAIT;
                    r_d.brk = 1'b1;
                end
            end
            ST_WAIT: begin
                if (fall) begin
                    r_d.st     = ST_MEAS;
                    meas_start = 1'b1;
                end
            end
            ST_MEAS: begin
                if (meas_done) begin
                    r_d.st   = ST_IDLE;
                    r_d.sync = 1'b1;
                    r_d.vld  = 1'b1;
                    r_d.per  = meas_per;
                end else if (meas_ovf) begin
                    r_d.st  = ST_BREAK;
                    r_d.err = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (arm_i) begin
            r_d.st     = ST_BREAK;
            meas_start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, brk: 1'b0, sync: 1'b0, err: 1'b0,
                             vld: 1'b0, per: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_IDLE: uart_rx_o = rx_s;
            ST_MEAS: uart_rx_o = sync_pass_i ? rx_s : 1'b1;
            default: uart_rx_o = 1'b1;
        endcase
    end

    assign brk_flag_o     = r_q.brk;
    assign sync_flag_o    = r_q.sync;
    assign err_flag_o     = r_q.err;
    assign brk_irq_o      = r_q.brk & brk_irq_en_i;
    assign sync_irq_o     = r_q.sync & sync_irq_en_i;
    assign bit_period_o   = r_q.per;
    assign period_valid_o = r_q.vld;

endmodule

// File: rtl/lin_hdr_autobaud_chk.sv
module lin_hdr_autobaud_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   brk_flag_clr_i,
    input logic                   brk_irq_en_i,
    input logic                   sync_irq_en_i,
    input logic                   uart_rx_o,
    input logic                   brk_flag_o,
    input logic                   sync_flag_o,
    input logic                   err_flag_o,
    input logic                   brk_irq_o,
    input logic                   sync_irq_o,
    input logic [CNT_W-4:0]       bit_period_o,
    input logic                   period_valid_o,
    input lin_hdr_pkg::lin_state_e state_q
);

    import lin_hdr_pkg::*;

    AST_UART_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BREAK || state_q == ST_WAIT) |-> uart_rx_o); // R3

    AST_BRK_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq_o |-> (brk_flag_o && brk_irq_en_i)); // R4

    AST_SYNC_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq_o |-> (sync_flag_o && sync_irq_en_i)); // R6

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid_o |=> !period_valid_o); // R6

    AST_VALID_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid_o |-> sync_flag_o); // R6

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_period_o) |-> period_valid_o); // R7

    AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag_clr_i && state_q != ST_BREAK) |=> !brk_flag_o); // R8

    AST_OVF_TO_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> (state_q == ST_BREAK)); // R9

endmodule

bind lin_hdr_autobaud lin_hdr_autobaud_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .brk_flag_clr_i (brk_flag_clr_i),
    .brk_irq_en_i   (brk_irq_en_i),
    .sync_irq_en_i  (sync_irq_en_i),
    .uart_rx_o      (uart_rx_o),
    .brk_flag_o     (brk_flag_o),
    .sync_flag_o    (sync_flag_o),
    .err_flag_o     (err_flag_o),
    .brk_irq_o      (brk_irq_o),
    .sync_irq_o     (sync_irq_o),
    .bit_period_o   (bit_period_o),
    .period_valid_o (period_valid_o),
    .state_q        (r_q.st)
);

// File: tb/lin_hdr_autobaud_tb.sv
module lin_hdr_autobaud_tb;

    localparam int CNT_W  = 16;
    localparam int BRK_W  = 20;
    localparam int THRESH = 20;
    localparam int NV     = 4;
    // vector table: bit period, sync pass-through, sync irq enable
    localparam int VP   [NV] = '{10, 16, 37, 120};
    localparam bit VPASS[NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam bit VIEN [NV] = '{1'b1, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1, arm = 1'b0, brk_ien = 1'b0, sync_ien = 1'b0, pass = 1'b0;
    logic bclr = 1'b0, sclr = 1'b0, eclr = 1'b0;
    logic [BRK_W-1:0] thresh = BRK_W'(THRESH);
    logic uart_rx, brk_f, sync_f, err_f, brk_irq, sync_irq, vld;
    logic [CNT_W-4:0] per;

    int checks = 0, errors = 0, vcnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lin_hdr_autobaud #(.CNT_W(CNT_W), .BRK_W(BRK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .arm_i(arm), .brk_thresh_i(thresh),
        .brk_irq_en_i(brk_ien), .sync_irq_en_i(sync_ien), .sync_pass_i(pass),
        .brk_flag_clr_i(bclr), .sync_flag_clr_i(sclr), .err_flag_clr_i(eclr),
        .uart_rx_o(uart_rx), .brk_flag_o(brk_f), .sync_flag_o(sync_f),
        .err_flag_o(err_f), .brk_irq_o(brk_irq), .sync_irq_o(sync_irq),
        .bit_period_o(per), .period_valid_o(vld)
    );

    always @(negedge clk) if (vld) vcnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx = v;
        end
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); bclr = 1'b1; sclr = 1'b1; eclr = 1'b1;
        @(negedge clk); bclr = 1'b0; sclr = 1'b0; eclr = 1'b0;
    endtask

    // break, delimiter, 55h LSB first with stop bit; samples uart_rx mid start bit
    task automatic send_header(input int p, input bit exp_pass);
        logic [9:0] frame;
        frame = {1'b1, 8'h55, 1'b0};
        hold(1'b0, THRESH + 5);
        hold(1'b1, 8);
        for (int b = 0; b < 10; b++) begin
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                if (b == 0 && c == p / 2)
                    chk("R10 uart_rx during sync", int'(uart_rx), exp_pass ? 0 : 1);
                rx = frame[b];
            end
        end
        hold(1'b1, 6);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset uart_rx", int'(uart_rx), 1);
        chk("R4 reset brk flag", int'(brk_f), 0);
        chk("R6 reset sync flag", int'(sync_f), 0);
        chk("R9 reset err flag", int'(err_f), 0);
        chk("R7 reset period", int'(per), 0);

        // R1: two-cycle synchroniser delay while idle
        rx = 1'b0;
        @(negedge clk); chk("R1 delay 1 cycle", int'(uart_rx), 1);
        @(negedge clk); chk("R1 delay 2 cycles", int'(uart_rx), 0);
        hold(1'b1, 4);

        // R2: a break without arming sets nothing
        hold(1'b0, THRESH * 3);
        hold(1'b1, 6);
        chk("R2 no flag unarmed", int'(brk_f), 0);

        // R4 boundary and R5 restart of the low count
        pulse_arm();
        hold(1'b0, 6);
        chk("R3 uart held while hunting", int'(uart_rx), 1);
        hold(1'b0, THRESH - 7);
        hold(1'b1, 4);
        chk("R4 one short of threshold", int'(brk_f), 0);
        hold(1'b0, THRESH - 1); hold(1'b1, 1); hold(1'b0, THRESH - 1); hold(1'b1, 4);
        chk("R5 split low runs", int'(brk_f), 0);
        hold(1'b0, THRESH); hold(1'b1, 4);
        chk("R4 exact threshold", int'(brk_f), 1);
        brk_ien = 1'b0; @(negedge clk);
        chk("R4 irq masked", int'(brk_irq), 0);
        brk_ien = 1'b1; @(negedge clk);
        chk("R4 irq enabled", int'(brk_irq), 1);
        hold(1'b0, 3);
        chk("R3 uart held after break", int'(uart_rx), 1);
        hold(1'b1, 4);
        @(negedge clk); bclr = 1'b1;
        @(negedge clk); bclr = 1'b0;
        @(negedge clk);
        chk("R8 brk clear", int'(brk_f), 0);

        // table of bit rates
        for (int v = 0; v < NV; v++) begin
            pass = VPASS[v];
            sync_ien = VIEN[v];
            vcnt = 0;
            pulse_arm();
            send_header(VP[v], VPASS[v]);
            chk("R4 brk flag per vector", int'(brk_f), 1);
            chk("R6 sync flag", int'(sync_f), 1);
            chk("R6 one valid pulse", vcnt, 1);
            chk("R6 sync irq", int'(sync_irq), int'(VIEN[v]));
            chk("R7 bit period", int'(per), VP[v]);
            rx = 1'b0;
            repeat (2) @(negedge clk);
            chk("R11 uart follows line", int'(uart_rx), 0);
            hold(1'b1, 4);
            chk("R11 uart follows high", int'(uart_rx), 1);
            @(negedge clk); sclr = 1'b1;
            @(negedge clk); sclr = 1'b0;
            @(negedge clk);
            chk("R8 sync clear only", int'(sync_f), 0);
            chk("R8 brk untouched", int'(brk_f), 1);
            clear_all();
        end

        // R9: overflow with only one falling edge
        pulse_arm();
        hold(1'b0, THRESH + 5);
        hold(1'b1, 8);
        hold(1'b0, 10);
        hold(1'b1, 66000);
        chk("R9 err flag", int'(err_f), 1);
        chk("R9 no sync flag", int'(sync_f), 0);
        chk("R9 period kept", int'(per), VP[NV-1]);
        @(negedge clk); bclr = 1'b1;
        @(negedge clk); bclr = 1'b0;
        // back in break detection without a new arm
        pass = 1'b0;
        send_header(12, 1'b0);
        chk("R9 rehunt brk", int'(brk_f), 1);
        chk("R9 rehunt sync", int'(sync_f), 1);
        chk("R9 rehunt period", int'(per), 12);
        @(negedge clk); eclr = 1'b1;
        @(negedge clk); eclr = 1'b0;
        @(negedge clk);
        chk("R8 err clear", int'(err_f), 0);
        chk("R8 sync kept", int'(sync_f), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule